// File: doc/BRIEF.md
# Address High Latch and Bank Decoder

The processor puts the upper and lower halves of a 16-bit memory address on the same eight address pins, one half after the other. While the high-address strobe is asserted, this block captures the upper half into an 8-bit register. It drives the held byte back out as address bits A15 to A8, so memory can see a full 16-bit address after the pins move on to the low half.

The upper four bits of the held byte feed a one-of-sixteen decoder. Each active-high output enables one 4 KB region of the 64 KB space: bank 0 starts at 0000h, bank 7 at 7000h, and bank 15 at F000h.

Two side inputs act on the decoder alone:
- A run-utility input makes the decoder treat the top address bit as 1. A start taken straight after reset then lands at 8000h, where the utility program lives.
- An active-low inhibit input blanks every bank select, so the whole memory system can be logically detached. The board ties this input high when it is unused.

Top module: `addr_hi_bank_dec`

## Requirements
- R1: A clock edge with `rst_n` low clears the held byte, so `addr_hi_o` reads 00h afterwards. With the inhibit high and the run-utility input low, `bank_sel_o` is then 0001h (bank 0).
- R2: A clock edge with `hi_strobe_i` high and `rst_n` high loads `addr_pins_i` into the held byte. `addr_hi_o` shows the new value from that edge onward.
- R3: A clock edge with `hi_strobe_i` low leaves `addr_hi_o` unchanged, whatever `addr_pins_i` carries.
- R4: With `bank_inhibit_n_i` high and `util_force_i` low, `bank_sel_o` bit k is high exactly when `addr_hi_o[7:4]` equals k. Bank k therefore covers addresses k*1000h to k*1000h+0FFFh, so bank 0 starts at 0000h and bank 7 at 7000h.
- R5: With `util_force_i` high and `bank_inhibit_n_i` high, the decoder uses index {1, `addr_hi_o[6:4]`}. After reset this selects bank 8, which starts at 8000h. The effect is combinational and needs no clock edge.
- R6: While `bank_inhibit_n_i` is low, every bit of `bank_sel_o` is 0, whatever the held byte or `util_force_i`. The held byte still loads normally on strobes.
- R7: Whenever `bank_inhibit_n_i` is high, exactly one bit of `bank_sel_o` is high.
- R8: `util_force_i` never alters `addr_hi_o`. Bit 7 of the exported byte keeps its captured value while the override is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| addr_pins_i | input | 8 | Multiplexed processor address lines |
| hi_strobe_i | input | 1 | High-address strobe; high captures the pins on the next edge |
| util_force_i | input | 1 | Run-utility override; decoder treats the top address bit as 1 |
| bank_inhibit_n_i | input | 1 | Active-low inhibit of all bank selects |
| addr_hi_o | output | 8 | Held high address byte (A15..A8) |
| bank_sel_o | output | 16 | One-hot active-high bank selects, bit k = bank k |

## Verification
The hardest case is the override acting on a held byte whose top bit is already 1. In that case the decoder output must not change and the exported byte must keep bit 7. This is reached only by first capturing such a byte through a strobe and then raising the run-utility input with the strobe held low. The bench does exactly that with 9Ch, and also raises the override straight after a reset to show the jump to bank 8. A second hard case is a strobe taken while the inhibit is low. The latch must still load, which the bench shows by releasing the inhibit and checking both the byte and the bank that reappears.

// File: rtl/ahb_pkg.sv
// Package for the address-high latch and bank decoder.
// Holds the default geometry shared by the design, the checker and the bench.
// Assumes the bank field is the top SEL bits of the held byte.
package ahb_pkg;
    localparam int HI_W_DEF     = 8;   // width of the held high address byte
    localparam int SEL_BITS_DEF = 4;   // bits of the byte that pick a bank
endpackage

// File: rtl/ahb_hi_latch.sv
// High-address holding register.
// Loads the multiplexed address pins on a clock edge where the capture
// enable is high; otherwise holds. Synchronous active-low reset to zero.
// Assumes the capture enable is already synchronous to clk.
module ahb_hi_latch #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cap_i,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    // Capture or hold the high byte; reset clears it.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q_o <= '0;
        else if (cap_i)
            q_o <= d_i;
    end
endmodule

// File: rtl/ahb_bank_decode.sv
// One-of-2**SEL bank decoder with a top-bit override and a global inhibit.
// The override ORs into the most significant index bit only; the inhibit
// gates every output to zero. Purely combinational.
// Assumes SEL >= 2.
module ahb_bank_decode #(
    parameter int SEL = 4,
    localparam int NB = 1 << SEL
) (
    input  logic [SEL-1:0] field_i,
    input  logic           force_msb_i,
    input  logic           inhibit_n_i,
    output logic [NB-1:0]  sel_o
);
    logic [SEL-1:0] idx;

    // Form the effective bank index with the override on its top bit.
    always_comb begin
        idx = {field_i[SEL-1] | force_msb_i, field_i[SEL-2:0]};
    end

    // One comparator per bank, each gated by the inhibit.
    for (genvar b = 0; b < NB; b++) begin : g_bank
        localparam logic [SEL-1:0] BANK_ID = SEL'(b);
        assign sel_o[b] = inhibit_n_i && (idx == BANK_ID);
    end
endmodule

// File: rtl/addr_hi_bank_dec.sv
// Address high latch and bank decoder, top level.
// Holds the high address byte captured on the high-address strobe, exports
// it, and decodes its top SEL_BITS into one-hot bank selects. A run-utility
// input forces the top decoder bit; an active-low input blanks all selects.
// Assumes all inputs are synchronous to clk.
module addr_hi_bank_dec
    import ahb_pkg::*;
#(
    parameter int HI_W     = HI_W_DEF,
    parameter int SEL_BITS = SEL_BITS_DEF,
    localparam int NBANK   = 1 << SEL_BITS
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [HI_W-1:0] addr_pins_i,
    input  logic            hi_strobe_i,
    input  logic            util_force_i,
    input  logic            bank_inhibit_n_i,
    output logic [HI_W-1:0] addr_hi_o,
    output logic [NBANK-1:0] bank_sel_o
);
    logic [HI_W-1:0]     hi_q;
    logic [SEL_BITS-1:0] bank_field;

    ahb_hi_latch #(.W(HI_W)) u_latch (
        .clk   (clk),
        .rst_n (rst_n),
        .cap_i (hi_strobe_i),
        .d_i   (addr_pins_i),
        .q_o   (hi_q)
    );

    // Pick the bank field from the top of the held byte.
    always_comb begin
        bank_field = hi_q[HI_W-1 -: SEL_BITS];
    end

    ahb_bank_decode #(.SEL(SEL_BITS)) u_dec (
        .field_i     (bank_field),
        .force_msb_i (util_force_i),
        .inhibit_n_i (bank_inhibit_n_i),
        .sel_o       (bank_sel_o)
    );

    assign addr_hi_o = hi_q;
endmodule

// File: rtl/ahb_bank_chk.sv
// Assertion checker for addr_hi_bank_dec, attached by bind.
// Relates the held byte, the strobe and the decoder outputs over time.
module ahb_bank_chk #(
    parameter int HI_W     = 8,
    parameter int SEL_BITS = 4,
    localparam int NBANK   = 1 << SEL_BITS
) (
    input logic             clk,
    input logic             rst_n,
    input logic [HI_W-1:0]  addr_pins_i,
    input logic             hi_strobe_i,
    input logic             util_force_i,
    input logic             bank_inhibit_n_i,
    input logic [HI_W-1:0]  addr_hi_o,
    input logic [NBANK-1:0] bank_sel_o
);
    AST_RESET_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> addr_hi_o == '0); // R1
    AST_STROBE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        hi_strobe_i |=> addr_hi_o == $past(addr_pins_i)); // R2
    AST_NO_STROBE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !hi_strobe_i |=> $stable(addr_hi_o)); // R3
    AST_FIELD_DECODE: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_inhibit_n_i && !util_force_i) |-> bank_sel_o[addr_hi_o[HI_W-1 -: SEL_BITS]]); // R4
    AST_FORCE_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_inhibit_n_i && util_force_i) |-> bank_sel_o[NBANK-1 -: NBANK/2] != '0); // R5
    AST_INHIBIT_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
        !bank_inhibit_n_i |-> bank_sel_o == '0); // R6
    AST_ONE_BANK: assert property (@(posedge clk) disable iff (!rst_n)
        bank_inhibit_n_i |-> $countones(bank_sel_o) == 1); // R7
    AST_FORCE_KEEPS_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        (util_force_i && !hi_strobe_i) |=> $stable(addr_hi_o)); // R8
endmodule

bind addr_hi_bank_dec ahb_bank_chk #(.HI_W(HI_W), .SEL_BITS(SEL_BITS)) u_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .addr_pins_i      (addr_pins_i),
    .hi_strobe_i      (hi_strobe_i),
    .util_force_i     (util_force_i),
    .bank_inhibit_n_i (bank_inhibit_n_i),
    .addr_hi_o        (addr_hi_o),
    .bank_sel_o       (bank_sel_o)
);

// File: tb/addr_hi_bank_dec_test.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver pushes expected results, the monitor compares.
module addr_hi_bank_dec_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  addr_pins_i = 8'h00;
    logic        hi_strobe_i = 1'b0;
    logic        util_force_i = 1'b0;
    logic        bank_inhibit_n_i = 1'b1;
    logic [7:0]  addr_hi_o;
    logic [15:0] bank_sel_o;

    typedef struct {
        logic [7:0]  addr;
        logic [15:0] sel;
        string       tag;
    } exp_t;

    exp_t        sb[$];
    int          checks = 0;
    int          failures = 0;
    logic [7:0]  model_hi = 8'h00;
    bit          done = 1'b0;

    always #2 clk = ~clk;

    addr_hi_bank_dec uut (
        .clk              (clk),
        .rst_n            (rst_n),
        .addr_pins_i      (addr_pins_i),
        .hi_strobe_i      (hi_strobe_i),
        .util_force_i     (util_force_i),
        .bank_inhibit_n_i (bank_inhibit_n_i),
        .addr_hi_o        (addr_hi_o),
        .bank_sel_o       (bank_sel_o)
    );

    // Expected bank selects from the requirements (R4, R5, R6).
    function automatic logic [15:0] exp_sel(logic [7:0] hi, logic frc, logic inh_n);
        logic [3:0] k;
        k = {hi[7] | frc, hi[6:4]};
        return inh_n ? (16'h0001 << k) : 16'h0000;
    endfunction

    // Drive one cycle of inputs and queue the result expected after the edge.
    task automatic step(input logic rst, input logic [7:0] pins, input logic stb,
                        input logic frc, input logic inh_n, input string tag);
        exp_t e;
        @(negedge clk);
        rst_n = rst;
        addr_pins_i = pins;
        hi_strobe_i = stb;
        util_force_i = frc;
        bank_inhibit_n_i = inh_n;
        if (!rst)      model_hi = 8'h00;
        else if (stb)  model_hi = pins;
        e.addr = model_hi;
        e.sel  = exp_sel(model_hi, frc, inh_n);
        e.tag  = tag;
        sb.push_back(e);
        @(posedge clk);
    endtask

    // Monitor: compare outputs shortly after each edge.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb.size() != 0) begin
                exp_t e;
                e = sb.pop_front();
                checks++;
                if (addr_hi_o !== e.addr || bank_sel_o !== e.sel) begin
                    failures++;
                    $display("FAIL %s: addr_hi=%02h sel=%04h expected addr_hi=%02h sel=%04h",
                             e.tag, addr_hi_o, bank_sel_o, e.addr, e.sel);
                end
            end
        end
    end

    // Watchdog.
    initial begin
        #800000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // R1: reset clears even with a strobe present
        step(1'b0, 8'hA5, 1'b1, 1'b0, 1'b1, "R1 reset clears byte");
        step(1'b0, 8'h00, 1'b0, 1'b0, 1'b1, "R1 reset selects bank 0");
        // R2: capture
        step(1'b1, 8'h12, 1'b1, 1'b0, 1'b1, "R2 capture 12h");
        // R3: hold with changing pins
        step(1'b1, 8'hFF, 1'b0, 1'b0, 1'b1, "R3 hold against FFh");
        step(1'b1, 8'h80, 1'b0, 1'b0, 1'b1, "R3 hold against 80h");
        // R4 and R7: every bank
        for (int k = 0; k < 16; k++)
            step(1'b1, {k[3:0], 4'h3}, 1'b1, 1'b0, 1'b1, "R4 R7 bank sweep");
        // R5: override on a low bank
        step(1'b1, 8'h25, 1'b1, 1'b0, 1'b1, "R2 capture 25h");
        step(1'b1, 8'h00, 1'b0, 1'b1, 1'b1, "R5 override 25h to bank 10");
        // R8: override on a byte with top bit set keeps byte
        step(1'b1, 8'h9C, 1'b1, 1'b0, 1'b1, "R2 capture 9Ch");
        step(1'b1, 8'h11, 1'b0, 1'b1, 1'b1, "R8 override keeps 9Ch");
        step(1'b1, 8'h11, 1'b0, 1'b0, 1'b1, "R8 override release");
        // R5 R8: override together with capture
        step(1'b1, 8'h31, 1'b1, 1'b1, 1'b1, "R5 R8 capture 31h under override");
        // R6: inhibit, still loads
        step(1'b1, 8'h77, 1'b1, 1'b0, 1'b0, "R6 inhibit during capture");
        step(1'b1, 8'h00, 1'b0, 1'b1, 1'b0, "R6 inhibit beats override");
        step(1'b1, 8'h00, 1'b0, 1'b0, 1'b1, "R6 release shows 77h bank 7");
        // R1 R5: start straight after reset lands at bank 8
        step(1'b0, 8'h00, 1'b0, 1'b0, 1'b1, "R1 second reset");
        step(1'b1, 8'h00, 1'b0, 1'b1, 1'b1, "R5 reset then override to 8000h");
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule